// File: doc/BRIEF.md
# Enhanced PMP Permission Checker

This block is the final decision step of a physical memory protection unit. Address matching and priority selection happen elsewhere. The caller hands over one of two things: the 8-bit configuration byte of the winning entry with a hit flag raised, or a cleared hit flag when nothing matched. Given the access kind and whether the hart runs in machine mode, the block answers at once whether the access may proceed. If it may not, the block says which access-fault class to raise.

Two rule sets are built in. The classic set lets machine mode pass unlocked entries freely and makes it obey locked ones. When the lockdown control bit is on, the lock bit stops acting as a lock and becomes an owner tag: it marks a region as machine-only or lower-privilege-only. Three permission codes then describe regions shared between the two privilege levels. A separate whitelist control bit, together with lockdown, decides what machine mode may do when no entry matches. A parameter removes the lockdown and whitelist support entirely.

The block is purely combinational and has no clock or reset. The answer follows the inputs within the same cycle.

Top module: `pmp_perm_check`

## Requirements
- R1: Configuration byte layout: bit 0 grants read, bit 1 grants write, bit 2 grants execute, bit 7 is the lock. Access codes: 00 read, 01 write, 10 execute. With lockdown off and a hit in machine mode, an entry whose bit 7 is 0 allows every access. An entry whose bit 7 is 1 allows only the accesses its bits 0..2 grant.
- R2: With lockdown off and a hit below machine mode, bits 0..2 (read, write, execute) alone decide, whatever bit 7 holds.
- R3: With lockdown on and a hit on an entry with lock=1, read=0, write=1, execute is allowed at both privilege levels. A write is denied. A read is allowed only in machine mode with bit 2 set.
- R4: With lockdown on and a hit on an entry with lock=0, read=0, write=1, execute is denied and a read is allowed at both levels. A write is allowed in machine mode, or at either level when bit 2 is set.
- R5: With lockdown on and a hit on configuration bits 7,2,1,0 all set, only reads are allowed, at both levels.
- R6: With lockdown on, every other entry encoding applies its bits 0..2 when machine mode meets lock=1 or a lower level meets lock=0. Any other pairing of privilege and lock is denied.
- R7: With no hit, every access below machine mode is denied.
- R8: With no hit in machine mode, the whitelist bit denies everything. Otherwise the lockdown bit denies execute only. Otherwise the access is allowed.
- R9: `fault_kind` is 00 whenever `allow` is 1. On a denial it is 01 for execute, 10 for read and 11 for write. Access code 11 is judged and tagged exactly as a write.
- R10: Configuration bits 3 to 6 (match mode and reserved) never change the decision.
- R11: With the parameter HAS_SECCFG set to 0, the lockdown and whitelist inputs have no effect: the classic rules and a plain machine-mode allow on no hit apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_code | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 write-class |
| priv_m | input | 1 | 1 when the effective privilege is machine mode |
| lockdown_en | input | 1 | Machine lockdown control bit |
| whitelist_en | input | 1 | Machine whitelist (deny by default) control bit |
| hit | input | 1 | 1 when an entry matched the address |
| entry_cfg | input | 8 | Configuration byte of the winning entry |
| allow | output | 1 | 1 when the access may proceed |
| fault_kind | output | 2 | Fault class on denial: 00 none, 01 fetch, 10 load, 11 store |

## Verification
The hardest cases are those where lockdown turns a reserved read-clear/write-set code into a shared region. Here a single bit (bit 2, or the privilege) flips the answer in opposite directions for read and for write. Machine mode with no hit is similarly tricky, because whitelist and lockdown both apply but whitelist takes priority. Directed checks place each of these combinations exactly. A sweep then drives every one of the 16384 input combinations to both the full and the reduced variant and compares each result against a behavioural model in the bench.

// File: rtl/pmp_perm_pkg.sv
// Shared types and field positions for the PMP permission checker.
// Assumes the 8-bit entry configuration layout used by every entry.
package pmp_perm_pkg;

    localparam int CFG_BITS  = 8;
    localparam int ACC_BITS  = 2;
    localparam int POS_READ  = 0;
    localparam int POS_WRITE = 1;
    localparam int POS_EXEC  = 2;
    localparam int POS_LOCK  = 7;

    typedef enum logic [ACC_BITS-1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_WCLS  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_FETCH = 2'b01,
        FLT_LOAD  = 2'b10,
        FLT_STORE = 2'b11
    } flt_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } acc_oh_t;

    typedef struct packed {
        logic l;
        logic r;
        logic w;
        logic x;
    } perm_t;

    // Turns the access code into one-hot form; code 11 joins the write class.
    function automatic acc_oh_t decode_acc(input logic [ACC_BITS-1:0] code);
        acc_oh_t oh;
        oh.rd = (code == ACC_READ);
        oh.ex = (code == ACC_EXEC);
        oh.wr = (code == ACC_WRITE) || (code == ACC_WCLS);
        return oh;
    endfunction

    // True when the entry's R/W/X bits grant the access.
    function automatic logic rwx_grants(input acc_oh_t oh, input perm_t p);
        return (oh.rd & p.r) | (oh.wr & p.w) | (oh.ex & p.x);
    endfunction

endpackage

// File: rtl/pmp_perm_classic.sv
// Classic rule set: machine mode obeys only locked entries, lower
// privileges always obey R/W/X. Assumes a hit on the supplied entry.
module pmp_perm_classic
    import pmp_perm_pkg::*;
(
    input  acc_oh_t acc,
    input  logic    priv_m,
    input  perm_t   perm,
    output logic    allow
);

    // Unlocked entries are transparent to machine mode.
    always_comb begin
        if (priv_m && !perm.l) begin
            allow = 1'b1;
        end else begin
            allow = rwx_grants(acc, perm);
        end
    end

endmodule

// File: rtl/pmp_perm_lockdown.sv
// Lockdown rule set: the lock bit tags ownership and three codes form
// shared regions. Assumes a hit on the supplied entry.
module pmp_perm_lockdown
    import pmp_perm_pkg::*;
(
    input  acc_oh_t acc,
    input  logic    priv_m,
    input  perm_t   perm,
    output logic    allow
);

    logic shared_code;
    logic shared_data;
    logic shared_ro;

    // Classifies the entry into one of the shared encodings.
    always_comb begin
        shared_code = perm.l && !perm.r && perm.w;
        shared_data = !perm.l && !perm.r && perm.w;
        shared_ro   = perm.l && perm.r && perm.w && perm.x;
    end

    // Applies the rule that belongs to the encoding.
    always_comb begin
        if (shared_code) begin
            allow = acc.ex || (acc.rd && priv_m && perm.x);
        end else if (shared_data) begin
            allow = acc.rd || (acc.wr && (priv_m || perm.x));
        end else if (shared_ro) begin
            allow = acc.rd;
        end else if (priv_m == perm.l) begin
            allow = rwx_grants(acc, perm);
        end else begin
            allow = 1'b0;
        end
    end

endmodule

// File: rtl/pmp_perm_nomatch.sv
// Decision when no entry matched. Lower privileges always fail; machine
// mode follows the whitelist and lockdown controls.
module pmp_perm_nomatch
    import pmp_perm_pkg::*;
(
    input  acc_oh_t acc,
    input  logic    priv_m,
    input  logic    lockdown,
    input  logic    whitelist,
    output logic    allow
);

    // Default policy for unmatched addresses.
    always_comb begin
        if (!priv_m) begin
            allow = 1'b0;
        end else if (whitelist) begin
            allow = 1'b0;
        end else if (lockdown) begin
            allow = !acc.ex;
        end else begin
            allow = 1'b1;
        end
    end

endmodule

// File: rtl/pmp_perm_check.sv
// Top of the PMP permission checker. Selects classic or lockdown rules on
// a hit, the default policy on a miss, and tags denials by access class.
// Assumes the caller already picked the highest-priority matching entry.
module pmp_perm_check
    import pmp_perm_pkg::*;
#(
    parameter bit HAS_SECCFG = 1'b1
)(
    input  logic [ACC_BITS-1:0] acc_code,
    input  logic                priv_m,
    input  logic                lockdown_en,
    input  logic                whitelist_en,
    input  logic                hit,
    input  logic [CFG_BITS-1:0] entry_cfg,
    output logic                allow,
    output logic [1:0]          fault_kind
);

    acc_oh_t acc;
    perm_t   perm;
    logic    ld_eff;
    logic    wl_eff;
    logic    classic_ok;
    logic    lockdown_ok;
    logic    nomatch_ok;
    logic    unused_cfg_bits;

    // Decodes the access and extracts the permission fields.
    always_comb begin
        acc    = decode_acc(acc_code);
        perm.l = entry_cfg[POS_LOCK];
        perm.r = entry_cfg[POS_READ];
        perm.w = entry_cfg[POS_WRITE];
        perm.x = entry_cfg[POS_EXEC];
    end

    assign unused_cfg_bits = ^entry_cfg[POS_LOCK-1:POS_EXEC+1];

    generate
        if (HAS_SECCFG) begin : g_seccfg
            assign ld_eff = lockdown_en;
            assign wl_eff = whitelist_en;
        end else begin : g_plain
            logic unused_ctrl;
            assign unused_ctrl = lockdown_en ^ whitelist_en;
            assign ld_eff = 1'b0;
            assign wl_eff = 1'b0;
        end
    endgenerate

    pmp_perm_classic u_classic (
        .acc    (acc),
        .priv_m (priv_m),
        .perm   (perm),
        .allow  (classic_ok)
    );

    pmp_perm_lockdown u_lockdown (
        .acc    (acc),
        .priv_m (priv_m),
        .perm   (perm),
        .allow  (lockdown_ok)
    );

    pmp_perm_nomatch u_nomatch (
        .acc       (acc),
        .priv_m    (priv_m),
        .lockdown  (ld_eff),
        .whitelist (wl_eff),
        .allow     (nomatch_ok)
    );

    // Picks the rule set and tags the fault class on denial.
    always_comb begin
        if (hit) begin
            allow = ld_eff ? lockdown_ok : classic_ok;
        end else begin
            allow = nomatch_ok;
        end
        if (allow) begin
            fault_kind = FLT_NONE;
        end else if (acc.ex) begin
            fault_kind = FLT_FETCH;
        end else if (acc.rd) begin
            fault_kind = FLT_LOAD;
        end else begin
            fault_kind = FLT_STORE;
        end
    end

endmodule

// File: rtl/pmp_perm_check_sva.sv
// Checker for the PMP permission checker: immediate assertions on the
// port relations, evaluated whenever the inputs settle. Bound to the top.
module pmp_perm_check_sva
    import pmp_perm_pkg::*;
#(
    parameter bit HAS_SECCFG = 1'b1
)(
    input logic [ACC_BITS-1:0] acc_code,
    input logic                priv_m,
    input logic                lockdown_en,
    input logic                whitelist_en,
    input logic                hit,
    input logic [CFG_BITS-1:0] entry_cfg,
    input logic                allow,
    input logic [1:0]          fault_kind
);

    logic ld;
    logic wl;
    logic is_ex;
    logic is_rd;

    // Local view of the effective controls and access class.
    always_comb begin
        ld    = HAS_SECCFG && lockdown_en;
        wl    = HAS_SECCFG && whitelist_en;
        is_ex = (acc_code == 2'b10);
        is_rd = (acc_code == 2'b00);
    end

    // Port relations that must hold for every input combination.
    always_comb begin
        assert_tag_iff_deny_R9: assert (allow == (fault_kind == 2'b00))
            else $error("tag and allow disagree");
        if (!allow) begin
            assert_tag_class_R9: assert (fault_kind == (is_ex ? 2'b01 : (is_rd ? 2'b10 : 2'b11)))
                else $error("wrong fault class");
        end
        if (!hit && !priv_m) begin
            assert_miss_lower_R7: assert (!allow) else $error("lower miss allowed");
        end
        if (!hit && priv_m && wl) begin
            assert_miss_whitelist_R8: assert (!allow) else $error("whitelist miss allowed");
        end
        if (hit && !ld && priv_m && !entry_cfg[7]) begin
            assert_unlocked_open_R1: assert (allow) else $error("unlocked entry denied machine");
        end
        if (hit && ld && entry_cfg[7] && !entry_cfg[0] && entry_cfg[1] && is_ex) begin
            assert_shared_exec_R3: assert (allow) else $error("shared code not executable");
        end
        if (hit && ld && entry_cfg[7] && (entry_cfg[2:0] == 3'b111)) begin
            assert_shared_ro_R5: assert (allow == is_rd) else $error("read-only region misjudged");
        end
    end

endmodule

bind pmp_perm_check pmp_perm_check_sva #(.HAS_SECCFG(HAS_SECCFG)) u_sva (
    .acc_code     (acc_code),
    .priv_m       (priv_m),
    .lockdown_en  (lockdown_en),
    .whitelist_en (whitelist_en),
    .hit          (hit),
    .entry_cfg    (entry_cfg),
    .allow        (allow),
    .fault_kind   (fault_kind)
);

// File: tb/pmp_perm_check_bench.sv
// Bench: directed checks on each rule, then a full sweep of all inputs
// against a behavioural model, on both the full and the reduced variant.
module pmp_perm_check_bench;

    logic       clk = 1'b0;
    logic [1:0] acc_code = 2'b00;
    logic       priv_m = 1'b0;
    logic       lockdown_en = 1'b0;
    logic       whitelist_en = 1'b0;
    logic       hit = 1'b0;
    logic [7:0] entry_cfg = 8'h00;
    logic       allow_full;
    logic [1:0] kind_full;
    logic       allow_plain;
    logic [1:0] kind_plain;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pmp_perm_check #(.HAS_SECCFG(1'b1)) u_pmp_perm_check (
        .acc_code (acc_code), .priv_m (priv_m), .lockdown_en (lockdown_en),
        .whitelist_en (whitelist_en), .hit (hit), .entry_cfg (entry_cfg),
        .allow (allow_full), .fault_kind (kind_full)
    );

    pmp_perm_check #(.HAS_SECCFG(1'b0)) u_pmp_perm_check_plain (
        .acc_code (acc_code), .priv_m (priv_m), .lockdown_en (lockdown_en),
        .whitelist_en (whitelist_en), .hit (hit), .entry_cfg (entry_cfg),
        .allow (allow_plain), .fault_kind (kind_plain)
    );

    // Behavioural reference: allow decision from the requirement text.
    function automatic bit model_allow(int acc, bit m, bit ld, bit wl, bit h, bit [7:0] c, bit feat);
        bit rd, wr, ex, lk, pr, pw, px, rwx;
        rd = (acc == 0); ex = (acc == 2); wr = (acc == 1) || (acc == 3);
        lk = c[7]; pr = c[0]; pw = c[1]; px = c[2];
        if (!feat) begin ld = 0; wl = 0; end
        rwx = (rd && pr) || (wr && pw) || (ex && px);
        if (!h) begin
            if (!m) return 0;
            if (wl) return 0;
            if (ld) return !ex;
            return 1;
        end
        if (!ld) return m ? (lk ? rwx : 1'b1) : rwx;
        if (lk && !pr && pw) return ex ? 1'b1 : (rd ? (m && px) : 1'b0);
        if (!lk && !pr && pw) return rd ? 1'b1 : (wr ? (m || px) : 1'b0);
        if (lk && pr && pw && px) return rd;
        if (m == lk) return rwx;
        return 0;
    endfunction

    function automatic bit [1:0] model_kind(int acc, bit ok);
        if (ok) return 2'b00;
        if (acc == 2) return 2'b01;
        if (acc == 0) return 2'b10;
        return 2'b11;
    endfunction

    // Names the requirement that governs a given input combination.
    function automatic string rule_tag(bit m, bit ld, bit h, bit [7:0] c, bit feat);
        if (!feat) return "R11";
        if (!h) return m ? "R8" : "R7";
        if (!ld) return m ? "R1" : "R2";
        if (c[7] && !c[0] && c[1]) return "R3";
        if (!c[7] && !c[0] && c[1]) return "R4";
        if (c[7] && c[2:0] == 3'b111) return "R5";
        return "R6";
    endfunction

    task automatic compare(string tag, bit plain, bit exp_ok, bit [1:0] exp_kind);
        bit a;
        bit [1:0] k;
        a = plain ? allow_plain : allow_full;
        k = plain ? kind_plain : kind_full;
        checks++;
        if (a !== exp_ok || k !== exp_kind) begin
            fails++;
            $display("FAIL %s acc=%0d m=%0b ld=%0b wl=%0b hit=%0b cfg=%h: allow=%0b kind=%0b expected allow=%0b kind=%0b",
                     tag, acc_code, priv_m, lockdown_en, whitelist_en, hit, entry_cfg, a, k, exp_ok, exp_kind);
        end
    endtask

    // Drives one directed vector at a rising edge, checks at the falling edge.
    task automatic directed(string tag, bit plain, int acc, bit m, bit ld, bit wl, bit h,
                            bit [7:0] c, bit exp_ok, bit [1:0] exp_kind);
        @(posedge clk);
        acc_code = 2'(acc); priv_m = m; lockdown_en = ld; whitelist_en = wl;
        hit = h; entry_cfg = c;
        @(negedge clk);
        compare(tag, plain, exp_ok, exp_kind);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        // Idle inputs: lower-privilege read with no hit, R7
        directed("R7", 0, 0, 0, 0, 0, 0, 8'h00, 0, 2'b10);
        directed("R7", 0, 2, 0, 1, 0, 0, 8'h00, 0, 2'b01);
        // R1: classic machine mode
        directed("R1", 0, 2, 1, 0, 0, 1, 8'h00, 1, 2'b00);
        directed("R1", 0, 1, 1, 0, 0, 1, 8'h81, 0, 2'b11);
        directed("R1", 0, 0, 1, 0, 0, 1, 8'h81, 1, 2'b00);
        // R2: classic lower privilege ignores lock
        directed("R2", 0, 2, 0, 0, 0, 1, 8'h05, 1, 2'b00);
        directed("R2", 0, 1, 0, 0, 0, 1, 8'h85, 0, 2'b11);
        // R3: shared code region
        directed("R3", 0, 0, 1, 1, 0, 1, 8'h82, 0, 2'b10);
        directed("R3", 0, 0, 1, 1, 0, 1, 8'h86, 1, 2'b00);
        directed("R3", 0, 0, 0, 1, 0, 1, 8'h86, 0, 2'b10);
        directed("R3", 0, 2, 0, 1, 0, 1, 8'h82, 1, 2'b00);
        directed("R3", 0, 1, 1, 1, 0, 1, 8'h86, 0, 2'b11);
        // R4: shared data region
        directed("R4", 0, 1, 0, 1, 0, 1, 8'h02, 0, 2'b11);
        directed("R4", 0, 1, 0, 1, 0, 1, 8'h06, 1, 2'b00);
        directed("R4", 0, 1, 1, 1, 0, 1, 8'h02, 1, 2'b00);
        directed("R4", 0, 2, 1, 1, 0, 1, 8'h06, 0, 2'b01);
        directed("R4", 0, 0, 0, 1, 0, 1, 8'h02, 1, 2'b00);
        // R5: shared read-only
        directed("R5", 0, 0, 0, 1, 0, 1, 8'h87, 1, 2'b00);
        directed("R5", 0, 1, 1, 1, 0, 1, 8'h87, 0, 2'b11);
        directed("R5", 0, 2, 1, 1, 0, 1, 8'h87, 0, 2'b01);
        // R6: ownership by lock bit
        directed("R6", 0, 0, 1, 1, 0, 1, 8'h01, 0, 2'b10);
        directed("R6", 0, 0, 0, 1, 0, 1, 8'h01, 1, 2'b00);
        directed("R6", 0, 0, 1, 1, 0, 1, 8'h81, 1, 2'b00);
        directed("R6", 0, 0, 0, 1, 0, 1, 8'h81, 0, 2'b10);
        // R8: machine miss policy, whitelist wins over lockdown
        directed("R8", 0, 0, 1, 1, 1, 0, 8'h00, 0, 2'b10);
        directed("R8", 0, 2, 1, 1, 0, 0, 8'h00, 0, 2'b01);
        directed("R8", 0, 0, 1, 1, 0, 0, 8'h00, 1, 2'b00);
        directed("R8", 0, 2, 1, 0, 0, 0, 8'h00, 1, 2'b00);
        // R9: code 11 behaves as a write
        directed("R9", 0, 3, 0, 0, 0, 1, 8'h03, 1, 2'b00);
        directed("R9", 0, 3, 0, 0, 0, 1, 8'h01, 0, 2'b11);
        // R10: match-mode bits do not matter
        directed("R10", 0, 0, 0, 0, 0, 1, 8'h19, 1, 2'b00);
        directed("R10", 0, 0, 0, 0, 0, 1, 8'h78, 0, 2'b10);
        // R11: reduced variant ignores lockdown and whitelist
        directed("R11", 1, 2, 1, 1, 1, 0, 8'h00, 1, 2'b00);
        directed("R11", 1, 0, 0, 1, 0, 1, 8'h81, 1, 2'b00);

        // Full sweep of every input combination on both variants
        for (int i = 0; i < 16384; i++) begin
            bit [13:0] v;
            bit ok_f, ok_p;
            v = 14'(i);
            @(posedge clk);
            acc_code = v[1:0]; priv_m = v[2]; lockdown_en = v[3];
            whitelist_en = v[4]; hit = v[5]; entry_cfg = v[13:6];
            @(negedge clk);
            ok_f = model_allow(int'(v[1:0]), v[2], v[3], v[4], v[5], v[13:6], 1'b1);
            ok_p = model_allow(int'(v[1:0]), v[2], v[3], v[4], v[5], v[13:6], 1'b0);
            compare(rule_tag(v[2], v[3], v[5], v[13:6], 1'b1), 0, ok_f, model_kind(int'(v[1:0]), ok_f));
            compare("R11", 1, ok_p, model_kind(int'(v[1:0]), ok_p));
        end

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule